// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial bus (SCL clock, SDA data) wrapped around a 4096-byte memory. Both bus lines come in as plain samples. SDA goes out as a pull-low enable, so the pad and pull-up stay outside the block. Three strap inputs give the device its identity, so eight such devices can share one bus.

A transfer opens with a slave byte. That byte carries the two top and two next address bits, three select bits and the direction flag. For a write, the master then sends the low eight address bits and one data byte. The byte is not stored until the master issues a stop. At the stop, a timed internal write cycle begins. While that cycle runs, the block is deaf: it ignores bus activity and acknowledges nothing.

For a read, the block sends bytes from an internal address pointer, most significant bit first. It keeps sending for as long as the master acknowledges. A random read is done by setting the pointer with a write header, then a repeated start and a read slave byte. Data moves only in whole bus bytes. There is no parallel data interface, so there is no valid/ready flow control. The busy output and the bus pins are plain control signals.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, busy_o is 0 and sda_pull_o is 0 (SDA released).
- R2: The slave byte is, MSB first, {A11, A10, D2, D1, D0, A9, A8, RW}. It matches only when D2 = ~strap_i[2], D1 = strap_i[1] and D0 = ~strap_i[0]. A non-matching slave byte gets no acknowledge, and the rest of that transfer is ignored until the next start.
- R3: Each accepted byte (matching slave byte, word address, first data byte) is acknowledged by holding SDA low through the ninth SCL pulse.
- R4: A byte write stores its data byte at address {A11, A10, A9, A8, word address}. If a repeated start arrives before the stop, the pending byte is discarded and the memory is left unchanged.
- R5: The stop that ends an acknowledged byte write raises busy_o one clock after the stop is detected. busy_o then stays high for exactly WR_CYCLES clocks.
- R6: While busy_o is high, the block never pulls SDA and ignores starts and bytes. A transfer attempted during that time gets no acknowledge and changes nothing.
- R7: A read sends the byte at the address pointer, MSB first, and advances the pointer by one. The pointer wraps from 4095 to 0.
- R8: Reading continues with the next byte after each master acknowledge (SDA low on the ninth pulse). It ends when the master does not acknowledge.
- R9: A word address sets the pointer to that full address. A committed write leaves the pointer at its address plus one. A read slave byte does not load the pointer.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes sent after a stop, with no new start, are ignored.
- R11: Bytes sent after the first data byte of a write are not acknowledged and not stored. The first data byte is still committed at the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 3 | Device identity straps {S2, S1, S0} |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
Random single-byte writes to random addresses, each read back by random reads of one to three bytes, check the 12-bit address join and the pointer advance. Directed patterns cover the rest. Writes at 4095 and 0 with a two-byte read tell wrap from overflow. A current-address read after a write tells the "address plus one" pointer apart from the write address. A write broken by a repeated start tells commit-at-stop from commit-on-receipt. An extra data byte separates single-byte writes from page behaviour. A slave byte sent inside the write cycle, and one sent after a stop without a start, separate real lockout and start gating from a slave that is merely slow. Slave bytes with one select bit flipped check the inverted and direct strap comparisons.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_BYTE_W = 8;
  localparam int TW_HI_W   = 4;
  localparam int TW_ADDR_W = TW_HI_W + TW_BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RD,
    ST_RD_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_line_detect.sv
module tw_line_detect #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_N-1:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sr   <= '1;
      sda_sr   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sr   <= {scl_sr[SYNC_N-2:0], scl_i};
      sda_sr   <= {sda_sr[SYNC_N-2:0], sda_i};
      scl_prev <= scl_sr[SYNC_N-1];
      sda_prev <= sda_sr[SYNC_N-1];
    end
  end

  assign scl_s    = scl_sr[SYNC_N-1];
  assign sda_s    = sda_sr[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      remain <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - CW'(1);
    end
  end
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import tw_pkg::*;
#(
  parameter int WR_CYCLES = 64,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(TW_BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TW_BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  tw_state_e state;
  logic [CNT_W-1:0] bcnt;
  logic [TW_BYTE_W-1:0] shreg;
  logic [TW_HI_W-1:0] hi_addr;
  logic [TW_ADDR_W-1:0] ptr, pend_addr;
  logic [TW_BYTE_W-1:0] pend_data, rdata;
  logic pend, rd_mode, more, pull;
  logic dev_match, launch, engaged;

  tw_line_detect #(.SYNC_N(SYNC_N)) u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tw_mem_array #(.AW(TW_ADDR_W), .DW(TW_BYTE_W)) u_mem (
    .clk(clk), .we(launch), .waddr(pend_addr), .wdata(pend_data),
    .raddr(ptr), .rdata(rdata)
  );

  tw_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy_o)
  );

  // select bits 2 and 0 compare inverted, bit 1 directly
  assign dev_match = (shreg[5] == ~strap_i[2]) && (shreg[4] == strap_i[1]) &&
                     (shreg[3] == ~strap_i[0]);
  assign launch     = stop_p & pend & ~busy_o;
  assign engaged    = (state != ST_IDLE);
  assign sda_pull_o = pull;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      shreg     <= '0;
      hi_addr   <= '0;
      ptr       <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      rd_mode   <= 1'b0;
      more      <= 1'b0;
      pull      <= 1'b0;
    end else if (busy_o) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
    end else if (start_p) begin
      state <= ST_DEV;
      bcnt  <= '0;
      pull  <= 1'b0;
      pend  <= 1'b0;
    end else if (stop_p) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
      if (pend) begin
        pend <= 1'b0;
        ptr  <= pend_addr + TW_ADDR_W'(1);
      end
    end else begin
      unique case (state)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[TW_BYTE_W-2:0], sda_s};
            bcnt  <= bcnt + CNT_W'(1);
          end else if (scl_fall && bcnt == FULL) begin
            if (state == ST_DEV) begin
              if (dev_match) begin
                pull    <= 1'b1;
                rd_mode <= shreg[0];
                hi_addr <= {shreg[7:6], shreg[2:1]};
                state   <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADR) begin
              ptr   <= {hi_addr, shreg};
              pull  <= 1'b1;
              state <= ST_WADR_ACK;
            end else begin
              pend      <= 1'b1;
              pend_addr <= ptr;
              pend_data <= shreg;
              pull      <= 1'b1;
              state     <= ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (rd_mode) begin
              shreg <= rdata;
              ptr   <= ptr + TW_ADDR_W'(1);
              pull  <= ~rdata[TW_BYTE_W-1];
              state <= ST_RD;
            end else begin
              pull  <= 1'b0;
              state <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            pull  <= 1'b0;
            bcnt  <= '0;
            state <= ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            pull  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bcnt <= bcnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (bcnt == FULL) begin
              pull  <= 1'b0;
              state <= ST_RD_ACK;
            end else begin
              pull  <= ~shreg[TW_BYTE_W-2];
              shreg <= {shreg[TW_BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            more <= ~sda_s;
          end else if (scl_fall) begin
            if (more) begin
              bcnt  <= '0;
              shreg <= rdata;
              ptr   <= ptr + TW_ADDR_W'(1);
              pull  <= ~rdata[TW_BYTE_W-1];
              state <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int WR_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic sda_pull_o,
  input logic stop_p,
  input logic engaged
);
  localparam int CW = $clog2(WR_CYCLES + 2);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + CW'(1);
    else busy_cnt <= '0;
  end

  // R6: no pull on SDA while the write cycle runs
  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  // R6: the transfer engine stays idle during the write cycle
  assert_deaf_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !engaged);

  // R5: the write cycle only ever begins right after a stop
  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_p));

  // R5: busy lasts exactly WR_CYCLES clocks
  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_cnt == CW'(WR_CYCLES));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(WR_CYCLES));

  // R3: SDA is pulled only inside an active transfer
  assert_pull_in_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> engaged);
endmodule

bind twowire_mem_slave tw_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_pull_o(sda_pull_o),
  .stop_p(stop_p), .engaged(engaged)
);

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;
  localparam int WR_CYC = 64;
  localparam logic [2:0] STRAP = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, busy;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  twowire_mem_slave #(.WR_CYCLES(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .busy_o(busy)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] ref_mem [4096];
  bit known [4096];
  logic [11:0] ref_ptr = '0;

  function automatic logic [7:0] dev_byte(input logic [11:0] a, input bit rw);
    return {a[11], a[10], ~STRAP[2], STRAP[1], ~STRAP[0], a[9], a[8], rw};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); sda_m = 1'b0; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask

  // stop, then measure the number of clocks busy stays high
  task automatic stop_commit(output int n);
    bit seen;
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1;
    n = 0; seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (busy) begin n++; seen = 1'b1; end
      else if (seen) break;
    end
  endtask

  // acked = 1 when the slave pulled SDA low on the ninth pulse
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(); scl_m = 1'b1; tick(); scl_m = 1'b0; tick();
    end
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick();
    acked = ~sda_line;
    scl_m = 1'b0; tick();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(); scl_m = 1'b1; tick();
      b = {b[6:0], sda_line};
      scl_m = 1'b0;
    end
    tick();
    sda_m = ~mack; tick(); scl_m = 1'b1; tick(); scl_m = 1'b0; tick();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    bit ak;
    int n;
    bus_start();
    send_byte(dev_byte(a, 1'b0), ak); check("R2 slave byte ack", ak, 1);
    send_byte(a[7:0], ak);            check("R3 word address ack", ak, 1);
    send_byte(d, ak);                 check("R3 data ack", ak, 1);
    stop_commit(n);                   check("R5 busy length", n, WR_CYC);
    ref_mem[a] = d; known[a] = 1'b1; ref_ptr = a + 12'd1;
  endtask

  task automatic rand_read(input logic [11:0] a, input int len);
    bit ak;
    logic [7:0] got;
    bus_start();
    send_byte(dev_byte(a, 1'b0), ak); check("R2 header ack", ak, 1);
    send_byte(a[7:0], ak);            check("R9 pointer load ack", ak, 1);
    bus_start();
    send_byte(dev_byte(12'h000, 1'b1), ak); check("R2 read slave byte ack", ak, 1);
    for (int i = 0; i < len; i++) begin
      logic [11:0] ea;
      ea = a + 12'(i);
      recv_byte(i < len - 1, got);
      if (known[ea]) check("R7 R8 sequential read data", got, ref_mem[ea]);
    end
    bus_stop();
    ref_ptr = a + 12'(len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    bit ak;
    int n;
    logic [7:0] got;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) known[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset pull", sda_pull, 0);

    // R2: one select bit wrong (S1 direct, S0 inverted)
    bus_start();
    send_byte(dev_byte(12'h010, 1'b0) ^ 8'h10, ak); check("R2 S1 mismatch no ack", ak, 0);
    send_byte(8'h10, ak);                          check("R2 rest ignored", ak, 0);
    bus_stop();
    bus_start();
    send_byte(dev_byte(12'h010, 1'b0) ^ 8'h08, ak); check("R2 S0 mismatch no ack", ak, 0);
    bus_stop();

    // R7 wrap and R8 continuation
    do_write(12'hFFF, 8'hA5);
    do_write(12'h000, 8'h3C);
    rand_read(12'hFFF, 2);

    // R9 current address read after write
    do_write(12'h201, 8'h5A);
    do_write(12'h200, 8'h77);
    bus_start();
    send_byte(dev_byte(12'hC00, 1'b1), ak); check("R9 current read ack", ak, 1);
    recv_byte(1'b0, got); check("R9 pointer is write address plus one", got, 8'h5A);
    bus_stop();

    // R4 repeated start discards pending write
    do_write(12'h300, 8'h10);
    bus_start();
    send_byte(dev_byte(12'h300, 1'b0), ak); check("R4 header ack", ak, 1);
    send_byte(8'h00, ak); check("R4 word ack", ak, 1);
    send_byte(8'hEE, ak); check("R4 data ack", ak, 1);
    bus_start();
    send_byte(dev_byte(12'h300, 1'b1), ak); check("R4 restart read ack", ak, 1);
    recv_byte(1'b0, got); check("R4 discarded byte not stored", got, 8'h10);
    stop_commit(n); check("R4 no write cycle", n, 0);

    // R11 extra byte after data
    bus_start();
    send_byte(dev_byte(12'h400, 1'b0), ak); check("R11 header ack", ak, 1);
    send_byte(8'h00, ak); check("R11 word ack", ak, 1);
    send_byte(8'h44, ak); check("R11 first data ack", ak, 1);
    send_byte(8'h55, ak); check("R11 extra byte not acked", ak, 0);
    stop_commit(n); check("R11 first byte committed", n, WR_CYC);
    ref_mem[12'h400] = 8'h44; known[12'h400] = 1'b1;
    ref_mem[12'h401] = 8'h66; known[12'h401] = 1'b0;
    do_write(12'h401, 8'h66);
    rand_read(12'h400, 2);

    // R6 lockout: new transfer started inside the write cycle
    bus_start();
    send_byte(dev_byte(12'h500, 1'b0), ak);
    send_byte(8'h00, ak);
    send_byte(8'h12, ak);
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
    check("R6 busy during lockout attempt", busy, 1);
    bus_start();
    send_byte(dev_byte(12'h500, 1'b0), ak); check("R6 no ack while busy", ak, 0);
    send_byte(8'h00, ak); check("R6 following byte ignored", ak, 0);
    send_byte(8'h99, ak); check("R6 data ignored", ak, 0);
    stop_commit(n); check("R6 no second write cycle", n, 0);
    ref_mem[12'h500] = 8'h12; known[12'h500] = 1'b1;
    rand_read(12'h500, 1);

    // R10 bytes after stop without start are ignored
    bus_start();
    send_byte(dev_byte(12'h000, 1'b0), ak); check("R10 ack after start", ak, 1);
    bus_stop();
    send_byte(dev_byte(12'h000, 1'b0), ak); check("R10 no ack without start", ak, 0);
    bus_stop();

    // random writes and read-backs
    for (int t = 0; t < 20; t++) begin
      logic [11:0] ra;
      logic [7:0] rd;
      ra = 12'($urandom % 4096);
      rd = 8'($urandom);
      do_write(ra, rd);
      rand_read(ra, 1 + int'($urandom % 3));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule